// File: doc/BRIEF.md
# Serial Transmit Channel with Clear-to-Send Gating

This block is one asynchronous serial transmit channel. A CPU-side port pushes characters into a four-entry queue. A serializer takes each character from the queue and sends it on `txd` as a framed character. Bit timing comes from an external 16x rate enable, `tick16`. Single-cycle command strobes enable the channel, disable it, reset it, and start or end a break. Frame shape is configurable: the data width, the parity and the stop-bit count.

Two status flags face the CPU. `tx_ready` says that a write will be accepted. `tx_empty` says that the line has gone quiet. A disable command does not cut traffic short: the queue drains first. A reset command cuts traffic off at once. An optional clear-to-send input can hold back the next character. It is examined only when a new character is about to start.

Top module: `utx_channel`

## Requirements
- R1: A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then the stop bits. `cfg_width` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Unused high data bits are not sent.
- R2: When `cfg_parity_en` is 1, one parity bit follows the data. With `cfg_parity_odd` = 0 the data bits plus the parity bit hold an even number of ones; with 1 they hold an odd number. When `cfg_parity_en` is 0, no parity bit is sent.
- R3: `cfg_two_stop` = 0 sends one high stop bit and `cfg_two_stop` = 1 sends two.
- R4: Every bit lasts exactly 16 cycles in which `tick16` is high. `txd` changes only on a cycle with `tick16` high or on a command. A character that is waiting starts on the first `tick16` cycle after it enters the queue.
- R5: `txd` idles high. `tx_empty` rises in the cycle after the last stop bit ends, provided the queue is empty at that point. An accepted write clears `tx_empty` on the next cycle.
- R6: An enable command sets `tx_empty` on the next cycle. If the queue is not full, it also sets `tx_ready`.
- R7: `tx_ready` is high exactly when the channel is enabled and the queue holds fewer than 4 characters. A write to a full queue is dropped.
- R8: A write while the channel is disabled is dropped. No character is sent for it, even after a later enable.
- R9: A disable command lowers `tx_ready` at once. The character in flight and every character already queued are still sent in full.
- R10: A reset command returns `txd` high on the next cycle. It also clears the enable, the break and `tx_empty`, and discards the queue. Nothing is sent until a new enable command and a new write.
- R11: A start-break command drives `txd` low from the next cycle until a stop-break command. No character starts while the break is active. A queued character starts after the break ends.
- R12: When `cts_check_en` is 1 and `cts_n` is high at a character boundary, no new character starts until `cts_n` goes low. A change on `cts_n` during a character leaves that character intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | 16x bit-rate enable |
| wr_en | input | 1 | Write strobe for the character queue |
| wr_data | input | 8 | Character to queue |
| cmd_enable | input | 1 | Enable command strobe |
| cmd_disable | input | 1 | Disable command strobe (drains the queue) |
| cmd_reset | input | 1 | Reset command strobe (aborts at once) |
| cmd_break_on | input | 1 | Start-break command strobe |
| cmd_break_off | input | 1 | Stop-break command strobe |
| cfg_width | input | 2 | Data width code, 0..3 for 5..8 bits |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cts_check_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Active-low clear-to-send |
| txd | output | 1 | Serial output line |
| tx_ready | output | 1 | A write will be accepted |
| tx_empty | output | 1 | Queue and shifter both finished |

## Verification
The hardest situations to reach from the ports are a queue that is both full and frozen, and a drain that continues after a disable. A character that starts right after its write leaves the queue again before more writes can land. The stimulus therefore holds `cts_n` high with gating enabled while it fills the queue and issues a disable. It then releases `cts_n` and raises it again partway through the first character. This shows that the character in flight completes and that the next one waits. Frame format is swept over all 24 combinations of width, parity mode and stop count, with exact-cycle checks on `tx_empty`. A second pass slows `tick16` to one cycle in three.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int FRAME_MAX = 12;
    localparam int LEN_W     = 4;

    typedef struct packed {
        logic [1:0] width;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } utx_cfg_t;

    // Bit vector sent LSB first: start, data, optional parity, stop fill.
    function automatic logic [FRAME_MAX-1:0] utx_frame(input logic [7:0] d,
                                                       input utx_cfg_t c);
        logic [FRAME_MAX-1:0] f;
        logic                 par;
        int                   nd;
        f   = '1;
        f[0] = 1'b0;
        nd  = 5 + int'(c.width);
        par = c.par_odd;
        for (int i = 0; i < 8; i++) begin
            if (i < nd) begin
                f[1 + i] = d[i];
                par      = par ^ d[i];
            end
        end
        if (c.par_en) begin
            f[1 + nd] = par;
        end
        return f;
    endfunction

    function automatic logic [LEN_W-1:0] utx_len(input utx_cfg_t c);
        return LEN_W'(7) + LEN_W'(c.width) + LEN_W'(c.par_en) + LEN_W'(c.two_stop);
    endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         full,
    output logic                         nonempty,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full     = (st_q.cnt == CW'(DEPTH));
    assign nonempty = (st_q.cnt != '0);
    assign level    = st_q.cnt;
    assign dout     = st_q.mem[st_q.rd];

    always_comb begin
        logic do_push, do_pop;
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && nonempty;
        if (do_push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr           = bump(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (level == CW'(DEPTH)));

endmodule

// File: rtl/utx_shift.sv
module utx_shift
    import utx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       flush,
    input  logic       hold,
    input  logic       avail,
    input  logic [7:0] data,
    input  utx_cfg_t   cfg,
    output logic       load,
    output logic       frame_done,
    output logic       busy,
    output logic       line
);
    localparam int PW = $clog2(OVERSAMPLE);

    typedef struct packed {
        logic                 busy;
        logic [FRAME_MAX-1:0] sr;
        logic [PW-1:0]        phase;
        logic [LEN_W-1:0]     left;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      last;

    assign busy = st_q.busy;
    assign line = st_q.busy ? st_q.sr[0] : 1'b1;

    always_comb begin
        st_d = st_q;
        last = st_q.busy && tick && (st_q.phase == PW'(OVERSAMPLE - 1)) &&
               (st_q.left == '0);
        load = tick && (!st_q.busy || last) && avail && !hold && !flush;
        if (st_q.busy && tick) begin
            if (st_q.phase == PW'(OVERSAMPLE - 1)) begin
                st_d.sr    = {1'b1, st_q.sr[FRAME_MAX-1:1]};
                st_d.left  = st_q.left - LEN_W'(1);
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + PW'(1);
            end
        end
        if (last) begin
            st_d.busy = 1'b0;
        end
        if (load) begin
            st_d.busy  = 1'b1;
            st_d.sr    = utx_frame(data, cfg);
            st_d.phase = '0;
            st_d.left  = utx_len(cfg) - LEN_W'(1);
        end
        if (flush) begin
            st_d = '0;
        end
        frame_done = last && !load && !flush;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_bit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !tick && !flush) |=> $stable(line));

    assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && !line));

endmodule

// File: rtl/utx_channel.sv
module utx_channel
    import utx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int QDEPTH     = 4,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              cmd_reset,
    input  logic              cmd_break_on,
    input  logic              cmd_break_off,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_two_stop,
    input  logic              cts_check_en,
    input  logic              cts_n,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty
);
    localparam int LW = $clog2(QDEPTH + 1);

    typedef struct packed {
        logic en;
        logic brk;
        logic empty;
    } chan_st_t;

    chan_st_t          st_d, st_q;
    logic              q_full, q_avail, q_pop, push_ok, hold;
    logic              sh_done, sh_busy, sh_line;
    logic [DATA_W-1:0] q_dout;
    logic [LW-1:0]     q_level;
    utx_cfg_t          cfg;

    assign cfg      = '{width: cfg_width, par_en: cfg_parity_en,
                        par_odd: cfg_parity_odd, two_stop: cfg_two_stop};
    assign push_ok  = wr_en && st_q.en && !q_full && !cmd_reset;
    assign hold     = st_q.brk || (cts_check_en && cts_n);
    assign txd      = st_q.brk ? 1'b0 : sh_line;
    assign tx_ready = st_q.en && !q_full;
    assign tx_empty = st_q.empty;

    utx_fifo #(.W(DATA_W), .DEPTH(QDEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (cmd_reset),
        .push     (push_ok),
        .din      (wr_data),
        .pop      (q_pop),
        .dout     (q_dout),
        .full     (q_full),
        .nonempty (q_avail),
        .level    (q_level)
    );

    utx_shift #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .flush      (cmd_reset),
        .hold       (hold),
        .avail      (q_avail),
        .data       (q_dout[7:0]),
        .cfg        (cfg),
        .load       (q_pop),
        .frame_done (sh_done),
        .busy       (sh_busy),
        .line       (sh_line)
    );

    always_comb begin
        st_d = st_q;
        if (cmd_disable) begin
            st_d.en = 1'b0;
        end else if (cmd_enable) begin
            st_d.en    = 1'b1;
            st_d.empty = 1'b1;
        end
        if (cmd_break_off) begin
            st_d.brk = 1'b0;
        end else if (cmd_break_on) begin
            st_d.brk = 1'b1;
        end
        if (sh_done && !q_avail) begin
            st_d.empty = 1'b1;
        end
        if (push_ok) begin
            st_d.empty = 1'b0;
        end
        if (cmd_reset) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_drop_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && wr_en) |=> (q_level <= $past(q_level)));

    assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (txd && !tx_ready && !tx_empty));

    assert_break_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_break_on && !cmd_break_off && !cmd_reset) |=> !txd);

    assert_cts_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_check_en && cts_n && !sh_busy) |=> !sh_busy);

    assert_enable_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_enable && !cmd_disable && !cmd_reset) |=> tx_empty);

    assert_txd_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick16 && !cmd_reset && !cmd_break_on && !cmd_break_off) |=> $stable(txd));

    assert_drain_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disable |=> !tx_ready);

endmodule

// File: tb/tb_utx_channel.sv
module tb_utx_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset = 1'b0;
    logic       cmd_break_on = 1'b0, cmd_break_off = 1'b0;
    logic [1:0] cfg_width = 2'd3;
    logic       cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       cts_check_en = 1'b0, cts_n = 1'b0;
    logic       txd, tx_ready, tx_empty;

    int n_vec = 0;
    int n_bad = 0;
    int tdiv = 1;
    int tcnt = 0;

    always #2.5 clk = ~clk;

    utx_channel dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .wr_en(wr_en), .wr_data(wr_data),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
        .cmd_break_on(cmd_break_on), .cmd_break_off(cmd_break_off),
        .cfg_width(cfg_width), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop),
        .cts_check_en(cts_check_en), .cts_n(cts_n),
        .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    always @(negedge clk) begin
        if (tdiv <= 1) begin
            tick16 <= 1'b1;
            tcnt   <= 0;
        end else begin
            tick16 <= (tcnt == 0);
            tcnt   <= (tcnt == tdiv - 1) ? 0 : tcnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // 0 enable, 1 disable, 2 reset, 3 break on, 4 break off
    task automatic cmd(input int code);
        @(negedge clk);
        cmd_enable    = (code == 0);
        cmd_disable   = (code == 1);
        cmd_reset     = (code == 2);
        cmd_break_on  = (code == 3);
        cmd_break_off = (code == 4);
        @(negedge clk);
        {cmd_enable, cmd_disable, cmd_reset, cmd_break_on, cmd_break_off} = '0;
    endtask

    function automatic int frame_bits();
        return 2 + (5 + int'(cfg_width)) + int'(cfg_parity_en) + int'(cfg_two_stop);
    endfunction

    function automatic logic [11:0] model(input logic [7:0] d);
        logic [11:0] v;
        int nd, ones, pos;
        v = 12'hfff; nd = 5 + int'(cfg_width); ones = 0; pos = 0;
        v[pos] = 1'b0; pos++;
        for (int i = 0; i < nd; i++) begin
            v[pos] = ((d >> i) & 8'd1) != 0;
            ones  += int'(v[pos]);
            pos++;
        end
        if (cfg_parity_en) begin
            v[pos] = ((ones % 2) == 1) ^ cfg_parity_odd;
        end
        return v;
    endfunction

    // Wait for a start bit, then sample each bit at its middle.
    task automatic rx_frame(input string req, input logic [7:0] d, input int cpb,
                            output int lat);
        logic [11:0] got;
        int n;
        lat = 0;
        while (txd !== 1'b0 && lat < 3000) begin
            @(negedge clk);
            lat++;
        end
        if (lat >= 3000) begin
            chk({req, " start timeout"}, 1, 0);
            return;
        end
        got = 12'hfff;
        n = frame_bits();
        cycles(cpb / 2);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            if (i < n - 1) cycles(cpb);
        end
        chk(req, {20'h0, got}, {20'h0, model(d)});
    endtask

    task automatic quiet_check(input string req, input int n);
        logic seen_low;
        seen_low = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) seen_low = 1'b1;
        end
        chk(req, {31'h0, seen_low}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int lat;
        logic [7:0] dv;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        chk("R10 reset txd", {31'h0, txd}, 1);
        chk("R7 reset ready", {31'h0, tx_ready}, 0);
        chk("R5 reset empty", {31'h0, tx_empty}, 0);

        // R8: write while disabled is dropped
        wr(8'h3c);
        quiet_check("R8 no frame while disabled", 40);
        cmd(0);
        chk("R6 enable ready", {31'h0, tx_ready}, 1);
        chk("R6 enable empty", {31'h0, tx_empty}, 1);
        quiet_check("R8 dropped char not sent after enable", 80);

        // R1 R2 R3 R4 R5 sweep of all frame shapes
        for (int w = 0; w < 4; w++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int k = 0; k < 2; k++) begin
                        @(negedge clk);
                        cfg_width      = 2'(w);
                        cfg_parity_en  = (pm != 0);
                        cfg_parity_odd = (pm == 2);
                        cfg_two_stop   = (s == 1);
                        dv = 8'((w * 53 + pm * 29 + s * 17 + k * 101 + 7) % 256);
                        wr(dv);
                        chk("R5 write clears empty", {31'h0, tx_empty}, 0);
                        chk("R4 idle before tick", {31'h0, txd}, 1);
                        rx_frame("R1 R2 R3 frame bits", dv, 16, lat);
                        chk("R4 start latency", lat, 1);
                        cycles(7);
                        chk("R5 empty still low in stop bit", {31'h0, tx_empty}, 0);
                        cycles(1);
                        chk("R5 empty after last stop", {31'h0, tx_empty}, 1);
                        chk("R5 idle high", {31'h0, txd}, 1);
                    end
                end
            end
        end

        // R4 slow tick: one enable every third cycle
        @(negedge clk);
        tdiv = 3;
        cfg_width = 2'd2; cfg_parity_en = 1'b1; cfg_parity_odd = 1'b0; cfg_two_stop = 1'b1;
        cycles(4);
        wr(8'h4d);
        rx_frame("R4 slow tick 7E2", 8'h4d, 48, lat);
        cfg_width = 2'd3; cfg_parity_en = 1'b0; cfg_two_stop = 1'b0;
        cycles(40);
        wr(8'hb2);
        rx_frame("R4 slow tick 8N1", 8'hb2, 48, lat);
        cycles(40);
        @(negedge clk);
        tdiv = 1;
        cycles(4);

        // R7 R12: fill the queue with CTS holding it
        cts_check_en = 1'b1; cts_n = 1'b1;
        wr(8'h11); wr(8'h22); wr(8'h33);
        chk("R7 ready with 3 queued", {31'h0, tx_ready}, 1);
        wr(8'h44);
        chk("R7 ready low when full", {31'h0, tx_ready}, 0);
        wr(8'h55);
        quiet_check("R12 held while cts high", 50);
        @(negedge clk); cts_n = 1'b0;
        cycles(3);
        cts_n = 1'b1;
        rx_frame("R12 char in flight completes", 8'h11, 16, lat);
        chk("R7 ready after one pop", {31'h0, tx_ready}, 1);
        quiet_check("R12 next char waits for cts", 60);
        @(negedge clk); cts_n = 1'b0;
        rx_frame("R7 order second", 8'h22, 16, lat);
        rx_frame("R7 order third", 8'h33, 16, lat);
        rx_frame("R7 order fourth", 8'h44, 16, lat);
        quiet_check("R7 write to full queue dropped", 80);
        chk("R5 empty after queue drained", {31'h0, tx_empty}, 1);

        // R9: disable drains the queue
        cts_n = 1'b1;
        wr(8'h61); wr(8'h72); wr(8'h83);
        cmd(1);
        chk("R9 ready drops on disable", {31'h0, tx_ready}, 0);
        wr(8'h94);
        @(negedge clk); cts_n = 1'b0;
        rx_frame("R9 drain first", 8'h61, 16, lat);
        rx_frame("R9 drain second", 8'h72, 16, lat);
        rx_frame("R9 drain third", 8'h83, 16, lat);
        quiet_check("R9 write during drain dropped", 80);
        chk("R9 empty after drain", {31'h0, tx_empty}, 1);
        cts_check_en = 1'b0;

        // R10: reset aborts and flushes
        cmd(0);
        wr(8'ha5); wr(8'h5a); wr(8'hc3);
        cycles(12);
        chk("R10 frame in progress", {31'h0, tx_empty}, 0);
        cmd(2);
        chk("R10 txd high after reset", {31'h0, txd}, 1);
        chk("R10 ready low after reset", {31'h0, tx_ready}, 0);
        chk("R10 empty low after reset", {31'h0, tx_empty}, 0);
        wr(8'h0f);
        quiet_check("R10 idle until enable", 40);
        cmd(0);
        quiet_check("R10 queue discarded", 100);
        chk("R6 empty after re-enable", {31'h0, tx_empty}, 1);

        // R11: break
        cmd(3);
        chk("R11 break drives low", {31'h0, txd}, 0);
        wr(8'he7);
        begin
            logic seen_high;
            seen_high = 1'b0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (txd !== 1'b0) seen_high = 1'b1;
            end
            chk("R11 break held low", {31'h0, seen_high}, 0);
        end
        cmd(4);
        chk("R11 stop break returns high", {31'h0, txd}, 1);
        rx_frame("R11 queued char after break", 8'he7, 16, lat);
        chk("R11 start one tick after break", lat, 1);

        cycles(20);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule